// File: doc/BRIEF.md
# UART FIFO Control and Interrupt Identification

This block holds the FIFO control logic of a 16550-style serial port and works out which pending interrupt the host should see. A host write to the FIFO control offset turns the transmit and receive FIFOs on or off, flushes either FIFO on request, and picks the receive trigger threshold. The same offset, when read, presents the interrupt identification byte, which this block produces combinationally from the interrupt enable bits and the status inputs coming from the rest of the port.

The FIFOs, shift registers, baud generator and the interrupt enable register itself sit outside. The block receives the enable bits and the receive FIFO fill count, and it sends back a FIFO-enable level, single-cycle flush strobes and the trigger threshold in bytes. The interrupt line is high whenever any enabled source is pending.

Top module: `uart_fifo_irq_ctl`

## Requirements
- R1: After reset fifo_en is 0, trig_level is 1, both flush strobes are 0, iir is 8'h01 and irq is 0.
- R2: A write at offset FCR_OFS (default 2) with data bit 0 set drives fifo_en to 1 and loads the trigger select from data bits 7:6 on the clock edge that takes the write. Writes at any other offset change nothing.
- R3: A write at offset FCR_OFS with data bit 0 clear drives fifo_en to 0 and raises rx_flush and tx_flush together for exactly one cycle, after that edge. Its bits 7:1 are not programmed, so the trigger select keeps its old value.
- R4: When data bit 0 is set, data bit 1 gives a one-cycle rx_flush strobe and data bit 2 gives a one-cycle tx_flush strobe, each independent of the other. Neither strobe stays high in the next cycle.
- R5: Data bits 3, 4 and 5 of the FIFO control write have no effect on any output.
- R6: With FIFO_DEPTH of 16, trigger select 00, 01, 10 and 11 give trig_level 1, 4, 8 and 14. A larger depth scales these values by FIFO_DEPTH/16.
- R7: The data-ready source is pending when enable bit 0 is set and, in FIFO mode, rx_count is at least trig_level, or, outside FIFO mode, rx_count is nonzero.
- R8: The sources rank as follows, highest first: line status (iir[3:1]=011, enable bit 2, input lsr_err), data ready (010), character timeout (110), transmit holding empty (001, enable bit 1, input thr_empty), modem status (000, enable bit 3, input msr_delta). iir[3:1] shows the highest pending source.
- R9: The character timeout source is pending only when enable bit 0 is set, fifo_en is 1 and rx_timeout is high.
- R10: iir[0] is 0 and irq is 1 exactly when some source is pending. iir[5:4] is always 00. iir[7:6] is 11 when fifo_en is 1 and 00 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Host write strobe |
| bus_addr | input | ADDR_W | Host register offset |
| bus_wdata | input | 8 | Host write data |
| ier | input | 4 | Interrupt enable bits: 0 data/timeout, 1 transmit empty, 2 line status, 3 modem |
| lsr_err | input | 1 | A line status error is pending |
| rx_count | input | CNT_W | Bytes held in the receive FIFO |
| rx_timeout | input | 1 | Receive character timeout has occurred |
| thr_empty | input | 1 | Transmit holding register is empty |
| msr_delta | input | 1 | A modem status bit has changed |
| fifo_en | output | 1 | FIFO mode active |
| rx_flush | output | 1 | One-cycle strobe to clear the receive FIFO |
| tx_flush | output | 1 | One-cycle strobe to clear the transmit FIFO |
| trig_level | output | CNT_W | Receive trigger threshold in bytes |
| iir | output | 8 | Interrupt identification value |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the status inputs are plain levels settled between clock edges, and that rx_count never exceeds FIFO_DEPTH. They also assume that bus_wr is low while reset is held. The bench changes status inputs and rx_count only while bus_wr is low, and it keeps rx_count within 0 to 16. It issues FIFO control writes one at a time, away from the active edge. The priority sweep runs every enable pattern against every status combination. It does this outside FIFO mode and in FIFO mode at each trigger setting, using fill counts placed on either side of each threshold.

// File: rtl/uart_fic_pkg.sv
package uart_fic_pkg;
   typedef enum logic [2:0] {
      IID_MODEM = 3'b000,
      IID_THRE  = 3'b001,
      IID_RDATA = 3'b010,
      IID_LINE  = 3'b011,
      IID_TMO   = 3'b110
   } iid_e;

   localparam int unsigned BASE_DEPTH = 16;
endpackage

// File: rtl/ufc_fcr_reg.sv
module ufc_fcr_reg #(
   parameter int unsigned ADDR_W  = 3,
   parameter int unsigned FCR_OFS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic              fifo_en,
   output logic [1:0]        trig_sel,
   output logic              rx_flush,
   output logic              tx_flush
);
   localparam logic [ADDR_W-1:0] OFS = ADDR_W'(FCR_OFS);

   logic hit;
   assign hit = bus_wr && (bus_addr == OFS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fifo_en  <= 1'b0;
         trig_sel <= 2'b00;
         rx_flush <= 1'b0;
         tx_flush <= 1'b0;
      end else begin
         rx_flush <= 1'b0;
         tx_flush <= 1'b0;
         if (hit) begin
            if (bus_wdata[0]) begin
               fifo_en  <= 1'b1;
               trig_sel <= bus_wdata[7:6];
               rx_flush <= bus_wdata[1];
               tx_flush <= bus_wdata[2];
            end else begin
               fifo_en  <= 1'b0;
               rx_flush <= 1'b1;
               tx_flush <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/ufc_trig_map.sv
module ufc_trig_map #(
   parameter int unsigned FIFO_DEPTH = 16,
   parameter int unsigned CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
   input  logic [1:0]       trig_sel,
   output logic [CNT_W-1:0] trig_level
);
   localparam int unsigned SCALE = FIFO_DEPTH / uart_fic_pkg::BASE_DEPTH;

   logic [4:0] base;
   always_comb begin
      case (trig_sel)
         2'b00:   base = 5'd1;
         2'b01:   base = 5'd4;
         2'b10:   base = 5'd8;
         default: base = 5'd14;
      endcase
   end

   generate
      if (SCALE == 1) begin : g_native
         assign trig_level = CNT_W'(base);
      end else begin : g_scaled
         assign trig_level = CNT_W'(base * SCALE);
      end
   endgenerate
endmodule

// File: rtl/ufc_irq_prio.sv
module ufc_irq_prio #(
   parameter int unsigned CNT_W = 5
) (
   input  logic [3:0]       ier,
   input  logic             fifo_en,
   input  logic [CNT_W-1:0] trig_level,
   input  logic             lsr_err,
   input  logic [CNT_W-1:0] rx_count,
   input  logic             rx_timeout,
   input  logic             thr_empty,
   input  logic             msr_delta,
   output logic [7:0]       iir,
   output logic             irq
);
   import uart_fic_pkg::*;

   logic src_line, src_data, src_tmo, src_thre, src_modem, any;
   iid_e code;

   assign src_line  = ier[2] & lsr_err;
   assign src_data  = ier[0] & (fifo_en ? (rx_count >= trig_level) : (rx_count != '0));
   assign src_tmo   = ier[0] & fifo_en & rx_timeout;
   assign src_thre  = ier[1] & thr_empty;
   assign src_modem = ier[3] & msr_delta;
   assign any = src_line | src_data | src_tmo | src_thre | src_modem;

   always_comb begin
      if (src_line)      code = IID_LINE;
      else if (src_data) code = IID_RDATA;
      else if (src_tmo)  code = IID_TMO;
      else if (src_thre) code = IID_THRE;
      else               code = IID_MODEM;
   end

   assign iir = {{2{fifo_en}}, 2'b00, code, ~any};
   assign irq = any;
endmodule

// File: rtl/uart_fifo_irq_ctl.sv
module uart_fifo_irq_ctl #(
   parameter int unsigned ADDR_W     = 3,
   parameter int unsigned FCR_OFS    = 2,
   parameter int unsigned FIFO_DEPTH = 16,
   parameter int unsigned CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   input  logic [3:0]        ier,
   input  logic              lsr_err,
   input  logic [CNT_W-1:0]  rx_count,
   input  logic              rx_timeout,
   input  logic              thr_empty,
   input  logic              msr_delta,
   output logic              fifo_en,
   output logic              rx_flush,
   output logic              tx_flush,
   output logic [CNT_W-1:0]  trig_level,
   output logic [7:0]        iir,
   output logic              irq
);
   generate
      if (FIFO_DEPTH < 16 || (FIFO_DEPTH % 16) != 0) begin : g_bad_depth
         $error("FIFO_DEPTH must be a nonzero multiple of 16");
      end
      if (FCR_OFS >= (1 << ADDR_W)) begin : g_bad_ofs
         $error("FCR_OFS does not fit in ADDR_W bits");
      end
   endgenerate

   logic [1:0] trig_sel;

   ufc_fcr_reg #(.ADDR_W(ADDR_W), .FCR_OFS(FCR_OFS)) u_fcr (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .fifo_en(fifo_en), .trig_sel(trig_sel),
      .rx_flush(rx_flush), .tx_flush(tx_flush)
   );

   ufc_trig_map #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_trig (
      .trig_sel(trig_sel), .trig_level(trig_level)
   );

   ufc_irq_prio #(.CNT_W(CNT_W)) u_prio (
      .ier(ier), .fifo_en(fifo_en), .trig_level(trig_level),
      .lsr_err(lsr_err), .rx_count(rx_count), .rx_timeout(rx_timeout),
      .thr_empty(thr_empty), .msr_delta(msr_delta), .iir(iir), .irq(irq)
   );
endmodule

// File: rtl/ufc_checker.sv
module ufc_checker #(
   parameter int unsigned ADDR_W  = 3,
   parameter int unsigned FCR_OFS = 2,
   parameter int unsigned CNT_W   = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [7:0]        bus_wdata,
   input logic [3:0]        ier,
   input logic              lsr_err,
   input logic              rx_timeout,
   input logic              fifo_en,
   input logic              rx_flush,
   input logic              tx_flush,
   input logic [CNT_W-1:0]  trig_level,
   input logic [7:0]        iir,
   input logic              irq
);
   logic hit;
   assign hit = bus_wr && (bus_addr == ADDR_W'(FCR_OFS));

   p_disable_flush_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !bus_wdata[0]) |=> (!fifo_en && rx_flush && tx_flush));

   p_keep_trig_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !bus_wdata[0]) |=> $stable(trig_level));

   p_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && bus_wdata[0]) |=> fifo_en);

   p_flush_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |=> (!rx_flush && !tx_flush));

   p_line_top_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ier[2] && lsr_err) |-> (iir[3:1] == 3'b011));

   p_tmo_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (iir[3:1] == 3'b110 && !iir[0]) |-> (fifo_en && rx_timeout));

   p_iir_fields_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (iir[5:4] == 2'b00) && (iir[7:6] == {2{fifo_en}}) && (irq == !iir[0]));
endmodule

bind uart_fifo_irq_ctl ufc_checker #(.ADDR_W(ADDR_W), .FCR_OFS(FCR_OFS), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .ier(ier), .lsr_err(lsr_err), .rx_timeout(rx_timeout),
   .fifo_en(fifo_en), .rx_flush(rx_flush), .tx_flush(tx_flush),
   .trig_level(trig_level), .iir(iir), .irq(irq)
);

// File: tb/sim_uart_fifo_irq_ctl.sv
module sim_uart_fifo_irq_ctl;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_wr = 1'b0;
   logic [2:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [3:0] ier = '0;
   logic lsr_err = 0, rx_timeout = 0, thr_empty = 0, msr_delta = 0;
   logic [4:0] rx_count = '0;
   logic fifo_en, rx_flush, tx_flush, irq;
   logic [4:0] trig_level;
   logic [7:0] iir;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   uart_fifo_irq_ctl u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .ier(ier), .lsr_err(lsr_err), .rx_count(rx_count),
      .rx_timeout(rx_timeout), .thr_empty(thr_empty), .msr_delta(msr_delta),
      .fifo_en(fifo_en), .rx_flush(rx_flush), .tx_flush(tx_flush),
      .trig_level(trig_level), .iir(iir), .irq(irq)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // write, then sample at the following negedge
   task automatic host_wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   function automatic int lvl_of(input int t);
      case (t)
         0: return 1;
         1: return 4;
         2: return 8;
         default: return 14;
      endcase
   endfunction

   function automatic int exp_iir(input int en, input int t, input int ie, input int st, input int cnt);
      int ln, dr, tm, th, ms, code, pend;
      ln = ie[2] & st[0];
      dr = ie[0] & (en ? (cnt >= lvl_of(t)) : (cnt != 0));
      tm = ie[0] & en & st[1];
      th = ie[1] & st[2];
      ms = ie[3] & st[3];
      pend = ln | dr | tm | th | ms;
      if (ln) code = 3;
      else if (dr) code = 2;
      else if (tm) code = 6;
      else if (th) code = 1;
      else code = 0;
      return (en ? 8'hC0 : 8'h00) | (code << 1) | (pend ? 0 : 1);
   endfunction

   initial begin
      static int counts[10] = '{0, 1, 3, 4, 7, 8, 13, 14, 15, 16};
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 fifo_en", fifo_en, 0);
      chk("R1 trig_level", trig_level, 1);
      chk("R1 flush", {rx_flush, tx_flush}, 0);
      chk("R1 iir", iir, 8'h01);
      chk("R1 irq", irq, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 other offsets ignored
      host_wr(3'd3, 8'hC1);
      chk("R2 other offset fifo_en", fifo_en, 0);
      chk("R2 other offset trig", trig_level, 1);
      host_wr(3'd2, 8'hC1);
      chk("R2 enable", fifo_en, 1);
      chk("R6 trig 11", trig_level, 14);
      chk("R4 no flush", {rx_flush, tx_flush}, 0);

      // R5 bits 3..5 no effect
      host_wr(3'd2, 8'h79);
      chk("R5 fifo_en", fifo_en, 1);
      chk("R5 flush", {rx_flush, tx_flush}, 0);
      chk("R6 trig 01", trig_level, 4);

      // R4 receive flush alone, then transmit alone
      host_wr(3'd2, 8'h83);
      chk("R4 rx_flush only", {rx_flush, tx_flush}, 2'b10);
      chk("R6 trig 10", trig_level, 8);
      @(negedge clk);
      chk("R4 rx self clear", {rx_flush, tx_flush}, 0);
      host_wr(3'd2, 8'h05);
      chk("R4 tx_flush only", {rx_flush, tx_flush}, 2'b01);
      chk("R6 trig 00", trig_level, 1);
      @(negedge clk);
      chk("R4 tx self clear", {rx_flush, tx_flush}, 0);

      // R3 disable: other bits not programmed
      host_wr(3'd2, 8'hC1);
      host_wr(3'd2, 8'h46);
      chk("R3 fifo_en off", fifo_en, 0);
      chk("R3 both flush", {rx_flush, tx_flush}, 2'b11);
      chk("R3 trig kept", trig_level, 14);
      @(negedge clk);
      chk("R3 one cycle", {rx_flush, tx_flush}, 0);

      // R7 R8 R9 R10 sweep: non-FIFO, then FIFO at each trigger
      for (int m = 0; m < 5; m++) begin
         int en, t;
         en = (m != 0);
         t = (m == 0) ? 3 : m - 1;
         if (m == 0) host_wr(3'd2, 8'h00);
         else host_wr(3'd2, 8'((t << 6) | 1));
         chk("R6 sweep trig", trig_level, en ? lvl_of(t) : 14);
         for (int ie = 0; ie < 16; ie++) begin
            for (int st = 0; st < 16; st++) begin
               for (int ci = 0; ci < 10; ci++) begin
                  int e;
                  ier = 4'(ie);
                  lsr_err = st[0]; rx_timeout = st[1]; thr_empty = st[2]; msr_delta = st[3];
                  rx_count = 5'(counts[ci]);
                  #1;
                  e = exp_iir(en, t, ie, st, counts[ci]);
                  chk("R7/R8/R9/R10 iir", iir, e);
                  chk("R10 irq", irq, (e & 1) ? 0 : 1);
               end
            end
         end
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #10_000_000;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule